// File: doc/BRIEF.md
# Serial Control Port Slave

This block is the slave end of a half-duplex serial control link. Through it a host reads and writes a small bank of 8-bit control registers. The host drives four signals: an active-low frame enable, a serial clock, a data line into the block, and it receives a data line back. Every transaction is one fixed frame of 16 serial clocks. The first byte is a command and the second byte is data. On a write the data byte comes in from the host, and on a read the block sends it out.

All three host signals pass through two-flop synchronizers into the system clock domain. Serial clock edges are found there by comparing successive samples. The system clock must therefore run several times faster than the fastest serial clock, which may reach 4.096 MHz and may also stop entirely. The register contents are available in parallel on a flat output bus for the logic they control.

Top module: `scp_slave`

## Requirements
- R1: After the asynchronous active-low reset, all registers, the bit counter and `sdo` are zero, and `sdo_oe` is low.
- R2: The block samples `sdi` on rising serial clock edges, most significant bit first. Frame bit 15, the first bit sent, is the read flag (1 = read, 0 = write). Frame bits 14:8 are the register address and frame bits 7:0 are the data byte. Register n occupies `regs_q[8n+7:8n]`.
- R3: A write changes the addressed register only on the 16th rising edge of a frame. If the enable rises after fewer than 16 rising edges, the frame is dropped and no register changes.
- R4: On a read, the addressed register is captured at the 8th rising edge. Its bits appear on `sdo`, most significant bit first, one per falling edge over the next 8 falling edges, so the host can sample each bit on the following rising edge.
- R5: `sdo` is held at zero and `sdo_oe` is low outside the read data phase. This covers the command byte, all of a write, and any time the enable is high.
- R6: During the read data phase `sdi` is ignored, and no register changes.
- R7: Serial clock edges are ignored while the enable is high. The bit counter restarts at zero for every frame, whatever the clock did between frames.
- R8: Rising edges beyond the 16th in a frame are ignored. An address at or above `NREGS` is not writable, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Frame enable from host, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| sdo_oe | output | 1 | High while `sdo` carries read data |
| regs_q | output | 8*NREGS | Register bank contents, register 0 in the low byte |

## Verification
The bench aims at aborted frames of every length from 1 to 15 rising edges. A design that commits early would corrupt a register there. It also sends frames with extra clocks after the 16th edge, which a counter that wraps would turn into a second, unintended transfer. Reads are sent with random data on `sdi` during the data phase, so a design that keeps shifting input would be caught changing the register. Addresses just past the bank check that the index is not wrapped into a real register. Serial clock pulses between frames expose a counter that keeps counting while the enable is high.

// File: rtl/scp_slave.sv
module scp_slave #(
  parameter int NREGS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sen_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [8*NREGS-1:0] regs_q
);
  localparam int DW = 8;
  localparam int FRAME = 16;
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [1:0] en_sy, ck_sy, di_sy;
  logic       ck_d;
  logic       sen_s, sck_s, sdi_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_sy <= '0;
      ck_sy <= '0;
      di_sy <= '0;
      ck_d  <= 1'b0;
    end else begin
      en_sy <= {en_sy[0], sen_n};
      ck_sy <= {ck_sy[0], sclk};
      di_sy <= {di_sy[0], sdi};
      ck_d  <= ck_sy[1];
    end

  assign sen_s = en_sy[1];
  assign sck_s = ck_sy[1];
  assign sdi_s = di_sy[1];
  assign rise  = sck_s & ~ck_d;
  assign fall  = ~sck_s & ck_d;

  logic [4:0]    cnt;
  logic [6:0]    cmd;
  logic [6:0]    addr_q;
  logic [6:0]    wbuf;
  logic [DW-1:0] tx;
  logic          rd_q, drive, sdo_q;
  logic [DW-1:0] regs [NREGS];
  logic [6:0]    addr_n;
  logic [DW-1:0] rd_val;
  logic          wr_hit;

  assign addr_n = {cmd[5:0], sdi_s};
  assign rd_val = (int'(addr_n) < NREGS) ? regs[addr_n[IW-1:0]] : '0;
  assign wr_hit = !sen_s && rise && cnt == 5'(FRAME - 1) && !rd_q
                  && int'(addr_q) < NREGS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      cmd    <= '0;
      addr_q <= '0;
      wbuf   <= '0;
      tx     <= '0;
      rd_q   <= 1'b0;
      drive  <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (sen_s) begin
      cnt   <= '0;
      rd_q  <= 1'b0;
      drive <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      if (rise && cnt < 5'(FRAME)) begin
        cnt <= cnt + 5'd1;
        if (cnt < 5'd7)
          cmd <= {cmd[5:0], sdi_s};
        else if (cnt == 5'd7) begin
          rd_q   <= cmd[6];
          addr_q <= addr_n;
          tx     <= rd_val;
        end else if (!rd_q)
          wbuf <= {wbuf[5:0], sdi_s};
      end
      if (fall && rd_q && cnt >= 5'd8 && cnt < 5'(FRAME)) begin
        drive <= 1'b1;
        sdo_q <= tx[DW-1];
        tx    <= {tx[DW-2:0], 1'b0};
      end else if (fall && cnt == 5'(FRAME)) begin
        drive <= 1'b0;
        sdo_q <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_hit) begin
      regs[addr_q[IW-1:0]] <= {wbuf, sdi_s};
    end

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_q[g*DW +: DW] = regs[g];
  end

  assign sdo    = drive ? sdo_q : 1'b0;
  assign sdo_oe = drive;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 5'(FRAME)); // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) sen_s |=> cnt == 5'd0 && !sdo_oe); // R7
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) sen_s |=> $stable(regs_q)); // R3
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> rd_q && cnt >= 5'd8); // R5
  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe |-> !sdo); // R5
  AST_READ_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n) rd_q |=> $stable(regs_q)); // R6
endmodule

// File: tb/tb_scp_slave.sv
module tb_scp_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 8;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0, sen_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [8*NREGS-1:0] regs_q;

  int checks = 0, errors = 0;
  logic [7:0] model [NREGS];

  scp_slave #(.NREGS(NREGS)) dut (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .regs_q(regs_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [8*NREGS-1:0] model_flat();
    logic [8*NREGS-1:0] f;
    for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  function automatic logic [7:0] model_read(input logic [6:0] a);
    return (int'(a) < NREGS) ? model[a[2:0]] : 8'h00;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
  endtask

  task automatic frame(input logic rd, input logic [6:0] a, input logic [7:0] d,
                       input int nbits);
    logic [15:0] bits;
    logic [7:0]  got;
    logic        quiet;
    bits  = {rd, a, d};
    got   = '0;
    quiet = 1'b1;
    sen_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16 && !(rd && i >= 8)) ? bits[15-i] : 1'($urandom);
      wait_clk(HALF);
      if (i >= 8 && i < 16 && rd) got[15-i] = sdo;
      if ((i < 8 || !rd) && (sdo !== 1'b0 || sdo_oe !== 1'b0)) quiet = 1'b0;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    sen_n = 1'b1;
    wait_clk(6);
    check("R5 sdo quiet outside read data", {63'b0, quiet}, 64'd1);
    check("R5 sdo low after frame", {62'b0, sdo, sdo_oe}, 64'd0);
    if (nbits >= 16) begin
      if (rd) check("R4 read data", {56'b0, got}, {56'b0, model_read(a)});
      else if (int'(a) < NREGS) model[a[2:0]] = d;
    end
    check(nbits < 16 ? "R3 aborted frame no change" :
          (rd ? "R6 read leaves regs" : "R2 write/R8 range"),
          64'(regs_q), 64'(model_flat()));
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    wait_clk(3);
    check("R1 reset regs", 64'(regs_q), 64'd0);
    check("R1 reset sdo", {62'b0, sdo, sdo_oe}, 64'd0);
    rst_n = 1'b1;
    wait_clk(3);

    frame(1'b0, 7'd3, 8'hA5, 16);
    frame(1'b1, 7'd3, 8'h00, 16);
    frame(1'b0, 7'd0, 8'h81, 16);
    frame(1'b1, 7'd0, 8'h00, 16);
    for (int n = 1; n < 16; n++) frame(1'b0, 7'd5, 8'hFF, n);  // R3
    frame(1'b0, 7'd8, 8'h77, 16);   // R8 out of range write
    frame(1'b1, 7'd8, 8'h00, 16);   // R8 out of range read
    frame(1'b1, 7'd127, 8'h00, 16); // R8
    frame(1'b0, 7'd7, 8'h3C, 20);   // R8 extra clocks
    frame(1'b1, 7'd7, 8'h00, 19);   // R8
    idle_pulses(3);                 // R7
    frame(1'b0, 7'd1, 8'h5A, 16);
    frame(1'b1, 7'd1, 8'h00, 16);

    for (int t = 0; t < 80; t++) begin
      logic       rd;
      logic [6:0] a;
      logic [7:0] d;
      int         nb;
      rd = 1'($urandom);
      a  = 7'($urandom_range(0, NREGS + 1));
      d  = 8'($urandom);
      nb = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 20)) : 16;
      idle_pulses(int'($urandom_range(0, 2))); // R7
      frame(rd, a, d, nb);
    end
    for (int i = 0; i < NREGS; i++) frame(1'b1, 7'(i), 8'h00, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule